// File: doc/BRIEF.md
# Eight-Line Victim Buffer with LRU Replacement

This block is a small fully-associative store that catches lines pushed out of a direct-mapped first-level data cache. Every slot keeps the whole line address as its tag, because nothing about a victim's address is implied by its position. Each line is 16 bytes. The cache offers each displaced line on the insert port. Before it goes to memory on a miss, it probes the lookup port with the missing line address.

A lookup is combinational: all tags are compared at once and the matching line's data comes back in the same cycle. A hit is a swap. The matched entry leaves the buffer because the line returns to the L1. The line that the L1 displaces at the same time is written into the slot that was freed, so occupancy does not change. Free slots are used before anything valid is evicted. When every slot is valid, a new line replaces the entry that was touched least recently. Dirty writeback is handled elsewhere.

Top module: `victim_cache`

## Requirements
- R1: After reset the buffer is empty: every lookup misses until a line has been inserted.
- R2: A lookup compares the full `LINE_W`-bit line address against every valid entry in the same cycle. Line addresses that differ only in their upper bits are distinct entries.
- R3: A lookup hit with no insert in the same cycle removes the entry. A later lookup of that line misses unless the line has been inserted again.
- R4: An inserted line is returned, with its 128-bit data, by the next lookup of its address.
- R5: While a free slot exists, an insert of a new address evicts nothing. Eight distinct inserts into an empty buffer all stay resident.
- R6: An insert of a new address into a full buffer, with no hit in that cycle, replaces the valid entry whose last insert was oldest.
- R7: A lookup hit together with an insert in the same cycle puts the inserted line in the freed slot. Occupancy is unchanged and no other entry is evicted.
- R8: An insert whose address is already resident (and not being removed in that cycle) overwrites that entry's data and makes it most recent. No duplicate is created.
- R9: When `lkp_valid` is low, or the lookup misses, `lkp_hit` is 0 and `lkp_data` is all zeros.
- R10: At most one entry ever matches a given line address.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lkp_valid | input | 1 | Lookup request |
| lkp_line | input | 28 | Line address to look up |
| lkp_hit | output | 1 | Lookup matched a valid entry (same cycle) |
| lkp_data | output | 128 | Data of the matching entry, zero on miss |
| ins_valid | input | 1 | Insert request (line displaced from the L1) |
| ins_line | input | 28 | Line address of the displaced line |
| ins_data | input | 128 | Data of the displaced line |

## Verification
The bench goes after eviction order once the buffer has filled. A design with a wrong recency update, or one that evicts while slots are still free, loses a line that should have survived, and the next lookup of that line misses. A swap in the same cycle must reuse the hit slot. A design that clears the slot after writing it, or that evicts an innocent entry, shows this as a missing line. Re-inserting a resident address must not create a twin. A duplicate would show up as stale data or as a second hit after the first one was removed. A comparison that ignores the upper address bits aliases lines such as 0x100 and 0x1100.

// File: rtl/vc_pkg.sv
package vc_pkg;
  localparam int unsigned VC_ENTRIES = 8;
  localparam int unsigned VC_LINE_W  = 28;
  localparam int unsigned VC_DATA_W  = 128;

  // index of the lowest set bit, 0 when none is set
  function automatic logic [4:0] lowest_set(input logic [31:0] v);
    logic [4:0] r;
    r = '0;
    for (int i = 31; i >= 0; i--) begin
      if (v[i]) r = 5'(i);
    end
    return r;
  endfunction

  // index of the single set bit of a one-hot vector
  function automatic logic [4:0] onehot_index(input logic [31:0] v);
    logic [4:0] r;
    r = '0;
    for (int i = 0; i < 32; i++) begin
      if (v[i]) r = r | 5'(i);
    end
    return r;
  endfunction

  function automatic logic [5:0] count_set(input logic [31:0] v);
    logic [5:0] c;
    c = '0;
    for (int i = 0; i < 32; i++) c = c + 6'(v[i]);
    return c;
  endfunction
endpackage

// File: rtl/vc_tag_match.sv
module vc_tag_match #(
  parameter int unsigned N      = vc_pkg::VC_ENTRIES,
  parameter int unsigned LINE_W = vc_pkg::VC_LINE_W
) (
  input  logic                   en,
  input  logic [LINE_W-1:0]      key,
  input  logic [N-1:0]           slot_valid,
  input  logic [N-1:0][LINE_W-1:0] slot_tag,
  output logic [N-1:0]           match
);
  for (genvar g = 0; g < N; g++) begin : g_cmp
    assign match[g] = en && slot_valid[g] && (slot_tag[g] == key);
  end
endmodule

// File: rtl/vc_lru_rank.sv
module vc_lru_rank #(
  parameter int unsigned N = vc_pkg::VC_ENTRIES,
  localparam int unsigned RW = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          touch_en,
  input  logic [RW-1:0] touch_idx,
  input  logic          drop_en,
  input  logic [RW-1:0] drop_idx,
  output logic [RW-1:0] oldest_idx
);
  localparam logic [RW-1:0] OLDEST = RW'(N - 1);

  // rank 0 is most recent, N-1 is least recent; ranks form a permutation
  logic [N-1:0][RW-1:0] rank_q, rank_drop, rank_next;
  logic [N-1:0]         is_oldest;

  always_comb begin
    rank_drop = rank_q;
    if (drop_en) begin
      for (int j = 0; j < N; j++) begin
        if (rank_q[j] > rank_q[drop_idx]) rank_drop[j] = rank_q[j] - 1'b1;
      end
      rank_drop[drop_idx] = OLDEST;
    end
    rank_next = rank_drop;
    if (touch_en) begin
      for (int j = 0; j < N; j++) begin
        if (rank_drop[j] < rank_drop[touch_idx]) rank_next[j] = rank_drop[j] + 1'b1;
      end
      rank_next[touch_idx] = '0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int j = 0; j < N; j++) rank_q[j] <= RW'(j);
    end else begin
      rank_q <= rank_next;
    end
  end

  for (genvar g = 0; g < N; g++) begin : g_old
    assign is_oldest[g] = (rank_q[g] == OLDEST);
  end

  always_comb begin
    oldest_idx = '0;
    for (int j = 0; j < N; j++) begin
      if (is_oldest[j]) oldest_idx = RW'(j);
    end
  end

  // R6
  one_oldest_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(is_oldest) == 1);
endmodule

// File: rtl/vc_store.sv
module vc_store #(
  parameter int unsigned N      = vc_pkg::VC_ENTRIES,
  parameter int unsigned LINE_W = vc_pkg::VC_LINE_W,
  parameter int unsigned DATA_W = vc_pkg::VC_DATA_W,
  localparam int unsigned RW = (N > 1) ? $clog2(N) : 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_en,
  input  logic [RW-1:0]            wr_idx,
  input  logic [LINE_W-1:0]        wr_tag,
  input  logic [DATA_W-1:0]        wr_data,
  input  logic                     clr_en,
  input  logic [RW-1:0]            clr_idx,
  output logic [N-1:0]             slot_valid,
  output logic [N-1:0][LINE_W-1:0] slot_tag,
  output logic [N-1:0][DATA_W-1:0] slot_data
);
  for (genvar g = 0; g < N; g++) begin : g_slot
    logic wr_here, clr_here;
    assign wr_here  = wr_en  && (wr_idx  == RW'(g));
    assign clr_here = clr_en && (clr_idx == RW'(g));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        slot_valid[g] <= 1'b0;
        slot_tag[g]   <= '0;
        slot_data[g]  <= '0;
      end else if (wr_here) begin
        slot_valid[g] <= 1'b1;
        slot_tag[g]   <= wr_tag;
        slot_data[g]  <= wr_data;
      end else if (clr_here) begin
        slot_valid[g] <= 1'b0;
      end
    end

    // R7: a slot is never cleared and written in one cycle
    no_clr_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_here && clr_here));
  end
endmodule

// File: rtl/victim_cache.sv
module victim_cache #(
  parameter int unsigned N      = vc_pkg::VC_ENTRIES,
  parameter int unsigned LINE_W = vc_pkg::VC_LINE_W,
  parameter int unsigned DATA_W = vc_pkg::VC_DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lkp_valid,
  input  logic [LINE_W-1:0] lkp_line,
  output logic              lkp_hit,
  output logic [DATA_W-1:0] lkp_data,
  input  logic              ins_valid,
  input  logic [LINE_W-1:0] ins_line,
  input  logic [DATA_W-1:0] ins_data
);
  import vc_pkg::*;
  localparam int unsigned RW    = (N > 1) ? $clog2(N) : 1;
  localparam int unsigned OCC_W = $clog2(N + 1);

  logic [N-1:0]             slot_valid;
  logic [N-1:0][LINE_W-1:0] slot_tag;
  logic [N-1:0][DATA_W-1:0] slot_data;
  logic [N-1:0]             lkp_match, ins_match_raw, ins_dup_vec;
  logic                     ins_dup, has_free, full;
  logic [4:0]               hit_idx5, dup_idx5, free_idx5;
  logic [RW-1:0]            hit_idx, dup_idx, free_idx, oldest_idx, wr_idx;
  logic                     clr_en;
  logic [OCC_W-1:0]         occ;

  vc_tag_match #(.N(N), .LINE_W(LINE_W)) u_lkp_match (
    .en(lkp_valid), .key(lkp_line), .slot_valid(slot_valid),
    .slot_tag(slot_tag), .match(lkp_match));

  vc_tag_match #(.N(N), .LINE_W(LINE_W)) u_ins_match (
    .en(ins_valid), .key(ins_line), .slot_valid(slot_valid),
    .slot_tag(slot_tag), .match(ins_match_raw));

  // a resident copy of the inserted line that is not leaving this cycle
  assign ins_dup_vec = ins_match_raw & ~lkp_match;
  assign ins_dup     = |ins_dup_vec;
  assign lkp_hit     = |lkp_match;
  assign has_free    = ~&slot_valid;
  assign full        = &slot_valid;

  assign hit_idx5  = onehot_index(32'(lkp_match));
  assign dup_idx5  = onehot_index(32'(ins_dup_vec));
  assign free_idx5 = lowest_set(32'(~slot_valid));
  assign hit_idx   = hit_idx5[RW-1:0];
  assign dup_idx   = dup_idx5[RW-1:0];
  assign free_idx  = free_idx5[RW-1:0];
  assign occ       = OCC_W'(count_set(32'(slot_valid)));

  always_comb begin
    if (ins_dup)       wr_idx = dup_idx;
    else if (lkp_hit)  wr_idx = hit_idx;
    else if (has_free) wr_idx = free_idx;
    else               wr_idx = oldest_idx;
  end

  // the hit slot empties unless the inserted line takes it over
  assign clr_en = lkp_hit && (!ins_valid || ins_dup);

  always_comb begin
    lkp_data = '0;
    for (int j = 0; j < N; j++) begin
      if (lkp_match[j]) lkp_data = lkp_data | slot_data[j];
    end
  end

  vc_store #(.N(N), .LINE_W(LINE_W), .DATA_W(DATA_W)) u_store (
    .clk(clk), .rst_n(rst_n),
    .wr_en(ins_valid), .wr_idx(wr_idx), .wr_tag(ins_line), .wr_data(ins_data),
    .clr_en(clr_en), .clr_idx(hit_idx),
    .slot_valid(slot_valid), .slot_tag(slot_tag), .slot_data(slot_data));

  vc_lru_rank #(.N(N)) u_lru (
    .clk(clk), .rst_n(rst_n),
    .touch_en(ins_valid), .touch_idx(wr_idx),
    .drop_en(clr_en), .drop_idx(hit_idx),
    .oldest_idx(oldest_idx));

  // R10
  single_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(lkp_match) && $onehot0(ins_match_raw));

  // R3
  hit_shrinks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lkp_hit && !ins_valid) |=> (occ == $past(occ) - 1'b1));

  // R7
  swap_keeps_occ_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lkp_hit && ins_valid && !ins_dup) |=> (occ == $past(occ)));

  // R5
  fill_grows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ins_valid && !lkp_hit && !ins_dup && !full) |=> (occ == $past(occ) + 1'b1));

  // R9
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !lkp_valid |-> (!lkp_hit && lkp_data == '0));
endmodule

// File: tb/tb_victim_cache.sv
module tb_victim_cache;
  localparam int N = 8;
  localparam int LW = 28;
  localparam int DW = 128;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic lkp_valid = 1'b0, ins_valid = 1'b0;
  logic [LW-1:0] lkp_line = '0, ins_line = '0;
  logic [DW-1:0] ins_data = '0;
  logic lkp_hit;
  logic [DW-1:0] lkp_data;

  always #2 clk = ~clk;

  victim_cache dut (.clk(clk), .rst_n(rst_n), .lkp_valid(lkp_valid),
    .lkp_line(lkp_line), .lkp_hit(lkp_hit), .lkp_data(lkp_data),
    .ins_valid(ins_valid), .ins_line(ins_line), .ins_data(ins_data));

  int checks = 0, errors = 0;
  bit finished = 1'b0;

  // reference: a set of lines with last-insert stamps
  bit          m_v[N];
  logic [LW-1:0] m_l[N];
  logic [DW-1:0] m_d[N];
  int          m_s[N];
  int          stamp = 0;

  function automatic int m_find(logic [LW-1:0] l);
    for (int i = 0; i < N; i++) if (m_v[i] && m_l[i] == l) return i;
    return -1;
  endfunction

  function automatic void m_update(bit lv, logic [LW-1:0] ll, bit iv,
                                   logic [LW-1:0] il, logic [DW-1:0] id);
    int h, k;
    if (lv) begin
      h = m_find(ll);
      if (h >= 0) m_v[h] = 1'b0;
    end
    if (iv) begin
      stamp++;
      k = m_find(il);
      if (k < 0) for (int i = 0; i < N; i++) if (!m_v[i] && k < 0) k = i;
      if (k < 0) begin
        k = 0;
        for (int i = 1; i < N; i++) if (m_s[i] < m_s[k]) k = i;
      end
      m_v[k] = 1'b1; m_l[k] = il; m_d[k] = id; m_s[k] = stamp;
    end
  endfunction

  task automatic check(string tag, bit ok, logic [DW-1:0] act, logic [DW-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // one clock: drive at the falling edge, compare lookup result, then commit
  task automatic cyc(string tag, bit lv, logic [LW-1:0] ll, bit iv,
                     logic [LW-1:0] il, logic [DW-1:0] id);
    int h;
    @(negedge clk);
    lkp_valid = lv; lkp_line = ll; ins_valid = iv; ins_line = il; ins_data = id;
    #1;
    h = lv ? m_find(ll) : -1;
    check({tag, " hit"}, lkp_hit == (h >= 0), DW'(lkp_hit), DW'(h >= 0));
    check({tag, " data"}, lkp_data == ((h >= 0) ? m_d[h] : '0), lkp_data,
          (h >= 0) ? m_d[h] : '0);
    @(posedge clk);
    m_update(lv, ll, iv, il, id);
  endtask

  function automatic logic [DW-1:0] rnd128();
    return {$urandom, $urandom, $urandom, $urandom};
  endfunction

  initial begin
    #(4 * 200000);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog actual=running expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4181));
    for (int i = 0; i < N; i++) begin m_v[i] = 0; m_s[i] = 0; end
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;

    // R1: empty after reset
    cyc("R1", 1, 28'h100, 0, '0, '0);
    cyc("R1", 1, 28'h0, 0, '0, '0);

    // R4 / R2: lines differing only in upper bits are separate
    cyc("R4", 0, '0, 1, 28'h100, 128'hB);
    cyc("R2", 1, 28'h1100, 1, 28'h1100, 128'hF);
    cyc("R2", 1, 28'h2100, 1, 28'h2100, 128'hA);
    // R9: no lookup, resident line must not show
    cyc("R9", 0, 28'h100, 0, '0, '0);
    // R7: swap 0x100 out, 0x2100's neighbour in
    cyc("R7", 1, 28'h100, 1, 28'h3100, 128'hC);
    // R3: 0x100 left on the swap
    cyc("R3", 1, 28'h100, 0, '0, '0);
    // R3: hit without insert removes
    cyc("R3", 1, 28'h1100, 0, '0, '0);
    cyc("R3", 1, 28'h1100, 0, '0, '0);
    // R8: re-insert resident line with new data
    cyc("R8", 0, '0, 1, 28'h2100, 128'hD);
    cyc("R8", 1, 28'h2100, 1, 28'h2100, 128'hD);

    // R5 / R6: reset and fill eight, then one more evicts the oldest
    @(negedge clk); rst_n = 1'b0;
    @(posedge clk); for (int i = 0; i < N; i++) m_v[i] = 0;
    @(negedge clk); rst_n = 1'b1;
    for (int i = 0; i < N; i++) cyc("R5", 0, '0, 1, 28'(i + 16), DW'(i + 100));
    for (int i = 0; i < N; i++) cyc("R5", 1, 28'(i + 16), 1, 28'(i + 16), DW'(i + 100));
    cyc("R6", 0, '0, 1, 28'h40, 128'h77);
    cyc("R6", 1, 28'(16), 0, '0, '0);
    cyc("R6", 1, 28'(17), 1, 28'(17), 128'h65);
    // R7: swap in a full buffer keeps everyone else
    cyc("R7", 1, 28'(18), 1, 28'h41, 128'h88);
    for (int i = 3; i < N; i++) cyc("R7", 1, 28'(i + 16), 1, 28'(i + 16), DW'(i + 100));

    // R4 / R7 / R8 / R6: random mix on a small pool of lines
    for (int n = 0; n < 4000; n++) begin
      logic [LW-1:0] a, b;
      bit lv, iv;
      a = 28'($urandom_range(0, 13)) | 28'h2000;
      b = 28'($urandom_range(0, 13)) | 28'h2000;
      if (($urandom & 3) == 0) b = a;
      lv = ($urandom & 3) != 0;
      iv = ($urandom & 1) != 0;
      cyc("R4", lv, a, iv, b, rnd128());
    end

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule